// File: doc/BRIEF.md
# Serial peripheral core with sequenced status flags

This block is a byte-wide serial peripheral port that a processor drives over a simple synchronous read/write bus with three registers: control, status and data. As a master it generates the serial clock itself and shifts one byte out while it shifts one byte in. As a slave it follows a clock and a select line supplied from outside. A transfer is started only by a data write while the block is the master. A data write while the block is a slave just places the byte in the shifter for the next externally clocked transfer.

Three status flags report a finished transfer, a data write that collided with a running transfer, and a master that was selected from outside. Each flag is cleared by a two-step sequence. First, a status read must see the flag set. Then a particular register access must follow. The receive side has a holding buffer between the shifter and the bus. The transmit side has none: a written byte goes straight into the shifter. An interrupt request follows the transfer-complete flag when interrupts are enabled.

Register addresses on `busAddr`: 0 selects control, 1 selects status, 2 selects data, and 3 reads as zero. Control bit 7 is the interrupt enable and control bit 4 selects master (1) or slave (0). All other control bits read as zero.

Top module: `spi_flag_core`

## Requirements
- R1: After reset every status and control bit is 0. Status bit 7 is transfer complete, bit 6 is write collision and bit 4 is mode fault. Status bits 5 and 3:0 always read 0.
- R2: Status bit 7 is set when a byte transfer finishes, both in master mode and in slave mode.
- R3: Status bit 7 clears only when a status read that saw it set is followed by a read or write of the data register. A data access with no such prior status read leaves the bit set.
- R4: `irq` is high exactly while status bit 7 and control bit 7 are both 1.
- R5: While status bit 7 is set and no status read has observed it, a data write is ignored completely: the shifter is not loaded, no transfer starts and no flag changes.
- R6: A data write accepted while a transfer is running sets status bit 6, and that transfer continues with its original byte. Bit 6 clears after a status read that saw it set, followed by any data access.
- R7: In master mode, a low `ssN` sets status bit 4, clears control bit 4 and aborts any running transfer without setting bit 7. Bit 4 clears only when a status read that saw it set is followed by a control write; a data access leaves it set.
- R8: Only a data write in master mode starts a transfer. A data write in slave mode loads the shifter, and that byte is shifted out most significant bit first on `sdoOut` while an external master clocks the block.
- R9: A data read returns the receive buffer. When a byte finishes while status bit 7 is still set, that byte is dropped and the buffer keeps the earlier byte.
- R10: A master transfer shifts out the written byte most significant bit first and captures `sdiIn` on each rising `sckOut` edge. With `sdoOut` looped back to `sdiIn`, the received byte equals the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |
| ssN | input | 1 | External slave select, active low |
| sckIn | input | 1 | Serial clock from an external master |
| sdiIn | input | 1 | Serial data in |
| sckOut | output | 1 | Serial clock driven in master mode, idle low |
| sdoOut | output | 1 | Serial data out, most significant bit of the shifter |

## Verification
The bench builds the core with a half bit period of two clock cycles. A master byte therefore takes about thirty cycles. This keeps these cases inside short directed runs:
- a collision written partway through a running transfer;
- an abort when the block is selected from outside;
- two back-to-back slave bytes that produce an overrun.

In slave mode the bench drives a slow external clock through the input synchronisers. In master mode it loops the serial output back to the input, so every received byte can be predicted from the byte written.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  localparam int CTRL_IEN  = 7;
  localparam int CTRL_MSTR = 4;

  typedef struct packed {
    logic              load;
    logic              start;
    logic              abort;
    logic              slaveMode;
    logic              rxAccept;
    logic [BYTE_W-1:0] loadData;
  } dpCtl_t;
endpackage

// File: rtl/spi_flag_dp.sv
module spi_flag_dp
  import spi_flag_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              ssN,
  input  logic              sckIn,
  input  logic              sdiIn,
  output logic              sckOut,
  output logic              sdoOut,
  output logic              busy,
  output logic              doneStb,
  output logic [BYTE_W-1:0] rxData
);
  localparam int DIV_W = $clog2(HALF_CYC + 1);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shifter;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              active;
  logic              sampleBit;
  logic [2:0]        sckPipe;
  logic [1:0]        ssPipe;
  logic              sckRise, sckFall, lastBit;
  logic [BYTE_W-1:0] nextShift;

  assign sckRise   = sckPipe[1] & ~sckPipe[2];
  assign sckFall   = ~sckPipe[1] & sckPipe[2];
  assign lastBit   = (bitCnt == CNT_W'(BYTE_W - 1));
  assign nextShift = {shifter[BYTE_W-2:0], sampleBit};
  assign sdoOut    = shifter[BYTE_W-1];
  assign busy      = active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      ssPipe  <= '1;
    end else begin
      sckPipe <= {sckPipe[1:0], sckIn};
      ssPipe  <= {ssPipe[0], ssN};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter   <= '0;
      divCnt    <= '0;
      bitCnt    <= '0;
      active    <= 1'b0;
      sampleBit <= 1'b0;
      sckOut    <= 1'b0;
      doneStb   <= 1'b0;
      rxData    <= '0;
    end else begin
      doneStb <= 1'b0;
      if (dpCtl.abort) begin
        active <= 1'b0;
        sckOut <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (dpCtl.load) begin
        shifter <= dpCtl.loadData;
        divCnt  <= '0;
        bitCnt  <= '0;
        sckOut  <= 1'b0;
        active  <= dpCtl.start;
      end else if (!dpCtl.slaveMode) begin
        if (active) begin
          if (divCnt == DIV_W'(HALF_CYC - 1)) begin
            divCnt <= '0;
            if (!sckOut) begin
              sckOut    <= 1'b1;
              sampleBit <= sdiIn;
            end else begin
              sckOut  <= 1'b0;
              shifter <= nextShift;
              bitCnt  <= bitCnt + 1'b1;
              if (lastBit) begin
                active  <= 1'b0;
                bitCnt  <= '0;
                doneStb <= 1'b1;
                if (dpCtl.rxAccept) rxData <= nextShift;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      end else begin
        sckOut <= 1'b0;
        if (ssPipe[1]) begin
          active <= 1'b0;
          bitCnt <= '0;
        end else if (sckRise) begin
          sampleBit <= sdiIn;
          active    <= 1'b1;
        end else if (sckFall && active) begin
          shifter <= nextShift;
          bitCnt  <= bitCnt + 1'b1;
          if (lastBit) begin
            active  <= 1'b0;
            bitCnt  <= '0;
            doneStb <= 1'b1;
            if (dpCtl.rxAccept) rxData <= nextShift;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              ssN,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [BYTE_W-1:0] rxData,
  output dpCtl_t            dpCtl,
  output logic [7:0]        statusBits,
  output logic              masterMode,
  output logic              intEn,
  output logic              irq
);
  logic [1:0] ssSync;
  logic doneFlag, wcolFlag, modfFlag;
  logic armDone, armWcol, armModf;
  logic rdStat, dataAcc, dataWr, ctrlWr;
  logic modeFaultNow, wrAllowed, collide;

  assign rdStat       = busSel & ~busWr & (busAddr == ADR_STAT);
  assign dataAcc      = busSel & (busAddr == ADR_DATA);
  assign dataWr       = dataAcc & busWr;
  assign ctrlWr       = busSel & busWr & (busAddr == ADR_CTRL);
  assign modeFaultNow = masterMode & ~ssSync[1];
  assign wrAllowed    = dataWr & ~(doneFlag & ~armDone);
  assign collide      = wrAllowed & dpBusy;

  always_comb begin
    dpCtl.load      = wrAllowed & ~dpBusy & ~modeFaultNow;
    dpCtl.start     = wrAllowed & ~dpBusy & ~modeFaultNow & masterMode;
    dpCtl.abort     = modeFaultNow | (ctrlWr & masterMode & ~busWdata[CTRL_MSTR]);
    dpCtl.slaveMode = ~masterMode;
    dpCtl.rxAccept  = ~doneFlag;
    dpCtl.loadData  = busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ssSync <= '1;
    else       ssSync <= {ssSync[0], ssN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag   <= 1'b0;
      wcolFlag   <= 1'b0;
      modfFlag   <= 1'b0;
      armDone    <= 1'b0;
      armWcol    <= 1'b0;
      armModf    <= 1'b0;
      masterMode <= 1'b0;
      intEn      <= 1'b0;
    end else begin
      if (rdStat) begin
        armDone <= doneFlag;
        armWcol <= wcolFlag;
        armModf <= modfFlag;
      end else begin
        if (dataAcc) begin
          armDone <= 1'b0;
          armWcol <= 1'b0;
        end
        if (ctrlWr) armModf <= 1'b0;
      end

      if (dpDone)                   doneFlag <= 1'b1;
      else if (dataAcc && armDone)  doneFlag <= 1'b0;

      if (collide)                  wcolFlag <= 1'b1;
      else if (dataAcc && armWcol)  wcolFlag <= 1'b0;

      if (modeFaultNow)             modfFlag <= 1'b1;
      else if (ctrlWr && armModf)   modfFlag <= 1'b0;

      if (modeFaultNow)  masterMode <= 1'b0;
      else if (ctrlWr)   masterMode <= busWdata[CTRL_MSTR];

      if (ctrlWr) intEn <= busWdata[CTRL_IEN];
    end
  end

  assign statusBits = {doneFlag, wcolFlag, 1'b0, modfFlag, 4'b0000};
  assign irq        = doneFlag & intEn;

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      unique case (busAddr)
        ADR_CTRL: begin
          busRdata[CTRL_IEN]  = intEn;
          busRdata[CTRL_MSTR] = masterMode;
        end
        ADR_STAT: busRdata = statusBits;
        ADR_DATA: busRdata = rxData;
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_flag_core.sv
module spi_flag_core
  import spi_flag_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq,
  input  logic       ssN,
  input  logic       sckIn,
  input  logic       sdiIn,
  output logic       sckOut,
  output logic       sdoOut
);
  dpCtl_t            dpCtl;
  logic              dpBusy, dpDone;
  logic [BYTE_W-1:0] rxData;
  logic [7:0]        statusBits;
  logic              masterMode, intEn;

  spi_flag_ctrl u_ctrl (
    .clk, .rstN, .busSel, .busWr, .busAddr, .busWdata, .busRdata,
    .ssN, .dpBusy, .dpDone, .rxData, .dpCtl, .statusBits,
    .masterMode, .intEn, .irq
  );

  spi_flag_dp #(.HALF_CYC(HALF_CYC)) u_dp (
    .clk, .rstN, .dpCtl, .ssN, .sckIn, .sdiIn, .sckOut, .sdoOut,
    .busy(dpBusy), .doneStb(dpDone), .rxData
  );
endmodule

// File: rtl/spi_flag_checker.sv
module spi_flag_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busRdata,
  input logic       irq,
  input logic       sckOut,
  input logic [7:0] statusBits,
  input logic       masterMode
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd1) |-> (busRdata[5] == 1'b0 && busRdata[3:0] == 4'b0)); // R1

  AST_DONE_CLEAR_BY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusBits[7]) |-> $past(busSel && busAddr == 2'd2)); // R3

  AST_IRQ_DROP_BY_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !busSel) |=> irq); // R4

  AST_WCOL_CLEAR_BY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusBits[6]) |-> $past(busSel && busAddr == 2'd2)); // R6

  AST_MODF_FORCES_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[4]) |-> !masterMode); // R7

  AST_MODF_CLEAR_BY_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusBits[4]) |-> $past(busSel && busWr && busAddr == 2'd0)); // R7

  AST_SLAVE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> !sckOut); // R8
endmodule

bind spi_flag_core spi_flag_checker u_chk (
  .clk, .rstN, .busSel, .busWr, .busAddr, .busRdata, .irq, .sckOut,
  .statusBits, .masterMode
);

// File: tb/spi_flag_core_bench.sv
`timescale 1ns/1ps
module spi_flag_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq, ssN = 1'b1, sckIn = 1'b0, sckOut, sdoOut;
  logic       loopEn = 1'b0, benchSdi = 1'b0;
  logic       sdiIn;
  int         checks = 0, fails = 0;
  bit         finished = 1'b0;

  assign sdiIn = loopEn ? sdoOut : benchSdi;

  always #4 clk = ~clk;

  spi_flag_core #(.HALF_CYC(2)) u_spi_flag_core (
    .clk, .rstN, .busSel, .busWr, .busAddr, .busWdata, .busRdata,
    .irq, .ssN, .sckIn, .sdiIn, .sckOut, .sdoOut
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #3 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slaveByte(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 7; i >= 0; i--) begin
      benchSdi = din[i];
      waitCyc(4);
      dout[i] = sdoOut;
      sckIn = 1'b1;
      waitCyc(4);
      sckIn = 1'b0;
      waitCyc(4);
    end
    waitCyc(6);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    busRead(2'd1, v); check("R1", "status after reset", v, 8'h00);
    busRead(2'd0, v); check("R1", "control after reset", v, 8'h00);
    check("R4", "irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_masterLoop();
    logic [7:0] v;
    loopEn = 1'b1;
    busWrite(2'd0, 8'h90);
    busWrite(2'd2, 8'hA5);
    waitCyc(50);
    check("R4", "irq on done with enable", {7'b0, irq}, 8'h01);
    busRead(2'd1, v); check("R2", "master done flag", v, 8'h80);
    busRead(2'd2, v); check("R10", "loopback byte", v, 8'hA5);
    busRead(2'd1, v); check("R3", "flag cleared by sequence", v, 8'h00);
    check("R4", "irq low after clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_blockedWrite();
    logic [7:0] v;
    logic sawClk;
    busWrite(2'd2, 8'hC3);
    waitCyc(50);
    busRead(2'd2, v); check("R9", "buffer read", v, 8'hC3);
    check("R3", "data read without status read keeps flag", {7'b0, irq}, 8'h01);
    busWrite(2'd2, 8'h00);
    sawClk = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sckOut) sawClk = 1'b1;
    end
    check("R5", "blocked write starts no clock", {7'b0, sawClk}, 8'h00);
    check("R5", "blocked write leaves shifter", {7'b0, sdoOut}, 8'h01);
    busRead(2'd1, v); check("R5", "status still done only", v, 8'h80);
    busWrite(2'd2, 8'h5A);
    waitCyc(50);
    busRead(2'd1, v); check("R5", "armed write starts new transfer", v, 8'h80);
    busRead(2'd2, v); check("R5", "armed write byte received", v, 8'h5A);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    busWrite(2'd2, 8'h66);
    waitCyc(5);
    busWrite(2'd2, 8'h11);
    waitCyc(45);
    busRead(2'd1, v); check("R6", "collision flag set", v, 8'hC0);
    busRead(2'd2, v); check("R6", "transfer kept original byte", v, 8'h66);
    busRead(2'd1, v); check("R6", "collision cleared by data access", v, 8'h00);
  endtask

  task automatic t_modeFault();
    logic [7:0] v;
    busWrite(2'd2, 8'hFF);
    waitCyc(4);
    ssN = 1'b0;
    waitCyc(6);
    busRead(2'd1, v); check("R7", "mode fault flag", v, 8'h10);
    busRead(2'd0, v); check("R7", "forced to slave", v, 8'h80);
    ssN = 1'b1;
    waitCyc(50);
    check("R7", "aborted transfer gives no done", {7'b0, irq}, 8'h00);
    busRead(2'd1, v);
    busWrite(2'd2, 8'h00);
    busRead(2'd1, v); check("R7", "data access keeps mode fault", v, 8'h10);
    busWrite(2'd0, 8'h90);
    busRead(2'd1, v); check("R7", "control write clears mode fault", v, 8'h00);
  endtask

  task automatic t_slave();
    logic [7:0] v, outb;
    logic sawClk;
    loopEn = 1'b0;
    busWrite(2'd0, 8'h80);
    busWrite(2'd2, 8'h96);
    sawClk = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sckOut) sawClk = 1'b1;
    end
    check("R8", "slave write starts no clock", {7'b0, sawClk}, 8'h00);
    check("R8", "slave write no done", {7'b0, irq}, 8'h00);
    ssN = 1'b0;
    slaveByte(8'h4D, outb);
    check("R8", "slave shifts written byte out", outb, 8'h96);
    busRead(2'd1, v); check("R2", "slave done flag", v, 8'h80);
    slaveByte(8'hB2, outb);
    ssN = 1'b1;
    busRead(2'd2, v); check("R9", "overrun keeps first byte", v, 8'h4D);
    busRead(2'd1, v); check("R3", "flag cleared after armed data read", v, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    t_reset();
    t_masterLoop();
    t_blockedWrite();
    t_collision();
    t_modeFault();
    t_slave();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule